// File: doc/BRIEF.md
# Audio Output Control Register Slave (write-only, two-wire)

This block is a write-only slave on a two-wire serial control bus (I2C-compatible). It configures a stereo headphone output stage. A fast system clock samples SCL and SDA, and the slave acknowledges by pulling SDA low through an open-drain pull-down output.

A write transaction has two bytes: a slave-address byte, then a single data byte. There is no register-address byte. The most significant bit of the data byte selects which of two internal registers receives the byte:

- **Mode register:** channel shut-offs, mutes, bias shut-off and a pump-only mode.
- **Volume register:** a global shutdown flag and a 6-bit volume code.

The two registers are decoded into the control outputs by a fixed priority. Global shutdown wins first. The pump-only mode comes next. The per-channel shut-off bits apply last, and a right-only shut-off folds the right input into the left output.

The system clock must run at least 8 times faster than SCL.

Top module: `audctl_i2c_slave`

## Requirements
- R1: After reset the mode register is all zeros and the volume register holds shutdown=1 with code 0. All enable outputs and `mono_sum_o` are 0, both mutes are 0, `vol_code_o` is 0 and `sda_pull_o` is 0.
- R2: A START (SDA falling while SCL is high), then the address 1100000 sent MSB first, then R/W=0, gets `sda_pull_o`=1 while SCL is high in the ninth clock. The data byte that follows is acknowledged the same way. Bits are taken on SCL rising edges.
- R3: An address byte other than 1100000 gets no acknowledge. The data byte after it is neither acknowledged nor stored.
- R4: An address byte 1100000 with R/W=1 gets no acknowledge. Every byte up to the next START is then ignored, including a byte that looks like a valid address.
- R5: Data bit 7 = 1 writes the volume register: bit 6 is global shutdown and bits 5:0 drive `vol_code_o` (0 = deepest attenuation, 63 = full gain). Data bit 7 = 0 writes the mode register.
- R6: While global shutdown is 1, `left_en_o`, `right_en_o`, `mono_sum_o`, `pump_en_o` and `bias_en_o` are all 0, whatever the mode register holds.
- R7: With shutdown 0 and mode bit 4 (pump-only) = 1, `pump_en_o`=1 and both channel enables and `bias_en_o` are 0, whatever the channel bits hold.
- R8: With shutdown 0 and pump-only 0, mode bit 6 = 1 turns the left channel off and mode bit 1 = 1 turns the right channel off. With only bit 1 set, `mono_sum_o`=1. With both bits set, both channels are off and `pump_en_o` stays 1.
- R9: In normal operation `bias_en_o` is the inverse of mode bit 5. Mode bit 3 has no effect on any output.
- R10: `mute_left_o` follows mode bit 2 and `mute_right_o` follows mode bit 0, in every power state.
- R11: A byte changes its register only after its acknowledge clock ends. A START or STOP inside a byte discards that byte.
- R12: Only one data byte is taken per transaction. Later bytes before the next START are neither acknowledged nor stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_pull_o | output | 1 | 1 = drive SDA low (acknowledge) |
| left_en_o | output | 1 | Left amplifier enable |
| right_en_o | output | 1 | Right amplifier enable |
| mono_sum_o | output | 1 | Mix right input into left output |
| pump_en_o | output | 1 | Negative-rail pump enable |
| bias_en_o | output | 1 | Bias generator enable |
| mute_left_o | output | 1 | Left channel mute |
| mute_right_o | output | 1 | Right channel mute |
| vol_code_o | output | 6 | Volume step code |

## Verification
Two actions fall on the same detected SCL falling edge at the end of the data acknowledge: the release of SDA and the register commit. The bench checks that the pull-down is still held at the middle of the ninth high phase, and that the outputs move to the new value only after that edge. A repeated START right after a committed acknowledge is also driven, to show that the commit survives and the next write still lands. A START or STOP is also placed inside a data byte, in the same cycles where a bit would otherwise be shifted in, and the bench checks that no register changes.

// File: rtl/audctl_pkg.sv
package audctl_pkg;

    localparam int VOL_W  = 6;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_ACKA,
        PH_DATA,
        PH_ACKD,
        PH_SKIP
    } bus_phase_e;

    typedef struct packed {
        logic left_off;
        logic bias_off;
        logic pump_only;
        logic mute_l;
        logic right_off;
        logic mute_r;
    } mode_t;

    typedef struct packed {
        logic             shdn;
        logic [VOL_W-1:0] code;
    } vol_t;

    typedef struct packed {
        logic             left_en;
        logic             right_en;
        logic             mono_sum;
        logic             pump_en;
        logic             bias_en;
        logic             mute_l;
        logic             mute_r;
        logic [VOL_W-1:0] vol;
    } ctrl_t;

    localparam mode_t MODE_RST = '0;
    localparam vol_t  VOL_RST  = '{shdn: 1'b1, code: '0};

    // priority: global shutdown, then pump-only, then per-channel bits
    function automatic ctrl_t decode_ctrl(mode_t m, vol_t v);
        ctrl_t c;
        c        = '0;
        c.mute_l = m.mute_l;
        c.mute_r = m.mute_r;
        c.vol    = v.code;
        if (!v.shdn) begin
            c.pump_en = 1'b1;
            if (!m.pump_only) begin
                c.bias_en  = !m.bias_off;
                c.left_en  = !m.left_off;
                c.right_en = !m.right_off;
                c.mono_sum = m.right_off && !m.left_off;
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/audctl_bus_sync.sv
module audctl_bus_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] din,
    output logic [LINES-1:0] dout
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-2:0], din[g]};
        end
        assign dout[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/audctl_wr_engine.sv
module audctl_wr_engine
    import audctl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1100000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_s,
    input  logic              sda_s,
    output logic              sda_pull,
    output logic              wr_en,
    output logic [BYTE_W-1:0] rx_byte,
    output bus_phase_e        ph
);
    logic             scl_p, sda_p;
    logic [CNT_W-1:0] bit_cnt;
    logic             ack_hi;
    logic             scl_rise, scl_fall, bus_start, bus_stop;

    assign scl_rise  = scl_s && !scl_p;
    assign scl_fall  = !scl_s && scl_p;
    assign bus_start = scl_s && scl_p && sda_p && !sda_s;
    assign bus_stop  = scl_s && scl_p && !sda_p && sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p    <= 1'b1;
            sda_p    <= 1'b1;
            ph       <= PH_IDLE;
            bit_cnt  <= '0;
            rx_byte  <= '0;
            ack_hi   <= 1'b0;
            sda_pull <= 1'b0;
            wr_en    <= 1'b0;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
            wr_en <= 1'b0;
            if (bus_start) begin
                ph       <= PH_ADDR;
                bit_cnt  <= '0;
                sda_pull <= 1'b0;
            end else if (bus_stop) begin
                ph       <= PH_IDLE;
                sda_pull <= 1'b0;
            end else begin
                case (ph)
                    PH_ADDR, PH_DATA: begin
                        if (scl_rise && bit_cnt < CNT_W'(BYTE_W)) begin
                            rx_byte <= {rx_byte[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == CNT_W'(BYTE_W)) begin
                            bit_cnt <= '0;
                            ack_hi  <= 1'b0;
                            if (ph == PH_DATA) begin
                                ph       <= PH_ACKD;
                                sda_pull <= 1'b1;
                            end else if (rx_byte == {DEV_ADDR, 1'b0}) begin
                                ph       <= PH_ACKA;
                                sda_pull <= 1'b1;
                            end else begin
                                ph <= PH_SKIP;
                            end
                        end
                    end
                    PH_ACKA, PH_ACKD: begin
                        if (scl_rise) begin
                            ack_hi <= 1'b1;
                        end else if (scl_fall && ack_hi) begin
                            sda_pull <= 1'b0;
                            if (ph == PH_ACKA) begin
                                ph <= PH_DATA;
                            end else begin
                                ph    <= PH_SKIP;
                                wr_en <= 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/audctl_regs.sv
module audctl_regs
    import audctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_byte,
    output mode_t             mode_q,
    output vol_t              vol_q,
    output ctrl_t             ctrl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_RST;
            vol_q  <= VOL_RST;
        end else if (wr_en) begin
            if (wr_byte[BYTE_W-1]) begin
                vol_q <= '{shdn: wr_byte[6], code: wr_byte[VOL_W-1:0]};
            end else begin
                mode_q <= '{left_off:  wr_byte[6],
                            bias_off:  wr_byte[5],
                            pump_only: wr_byte[4],
                            mute_l:    wr_byte[2],
                            right_off: wr_byte[1],
                            mute_r:    wr_byte[0]};
            end
        end
    end

    assign ctrl = decode_ctrl(mode_q, vol_q);
endmodule

// File: rtl/audctl_i2c_slave.sv
module audctl_i2c_slave
    import audctl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b1100000,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_pull_o,
    output logic             left_en_o,
    output logic             right_en_o,
    output logic             mono_sum_o,
    output logic             pump_en_o,
    output logic             bias_en_o,
    output logic             mute_left_o,
    output logic             mute_right_o,
    output logic [VOL_W-1:0] vol_code_o
);
    logic [1:0]        bus_s;
    logic              wr_en_w;
    logic [BYTE_W-1:0] rx_byte_w;
    bus_phase_e        ph_w;
    mode_t             mode_q_w;
    vol_t              vol_q_w;
    ctrl_t             ctrl_w;

    audctl_bus_sync #(.LINES(2), .STAGES(SYNC_STAGES)) sync_i (
        .clk (clk),
        .rst (rst),
        .din ({scl_i, sda_i}),
        .dout(bus_s)
    );

    audctl_wr_engine #(.DEV_ADDR(DEV_ADDR)) eng_i (
        .clk     (clk),
        .rst     (rst),
        .scl_s   (bus_s[1]),
        .sda_s   (bus_s[0]),
        .sda_pull(sda_pull_o),
        .wr_en   (wr_en_w),
        .rx_byte (rx_byte_w),
        .ph      (ph_w)
    );

    audctl_regs regs_i (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en_w),
        .wr_byte(rx_byte_w),
        .mode_q (mode_q_w),
        .vol_q  (vol_q_w),
        .ctrl   (ctrl_w)
    );

    assign left_en_o    = ctrl_w.left_en;
    assign right_en_o   = ctrl_w.right_en;
    assign mono_sum_o   = ctrl_w.mono_sum;
    assign pump_en_o    = ctrl_w.pump_en;
    assign bias_en_o    = ctrl_w.bias_en;
    assign mute_left_o  = ctrl_w.mute_l;
    assign mute_right_o = ctrl_w.mute_r;
    assign vol_code_o   = ctrl_w.vol;
endmodule

// File: rtl/audctl_i2c_slave_chk.sv
module audctl_i2c_slave_chk
    import audctl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1100000
) (
    input logic              clk,
    input logic              rst,
    input bus_phase_e        ph,
    input logic [BYTE_W-1:0] rx_byte,
    input logic              wr_en,
    input mode_t             mode_q,
    input vol_t              vol_q,
    input logic              sda_pull,
    input logic              left_en,
    input logic              right_en,
    input logic              mono_sum,
    input logic              pump_en,
    input logic              bias_en
);
    // R2
    ack_phase_chk: assert property (@(posedge clk) disable iff (rst)
        sda_pull |-> (ph == PH_ACKA || ph == PH_ACKD));

    // R3 R4
    ack_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_ACKA) |-> (rx_byte == {DEV_ADDR, 1'b0}));

    // R11
    commit_only_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_en) |-> ($stable(mode_q) && $stable(vol_q)));

    // R6
    shdn_override_chk: assert property (@(posedge clk) disable iff (rst)
        vol_q.shdn |-> !(left_en || right_en || mono_sum || pump_en || bias_en));

    // R7
    pump_only_chk: assert property (@(posedge clk) disable iff (rst)
        (!vol_q.shdn && mode_q.pump_only) |-> (pump_en && !left_en && !right_en && !bias_en));

    // R8
    mono_chk: assert property (@(posedge clk) disable iff (rst)
        mono_sum |-> (left_en && !right_en));
endmodule

bind audctl_i2c_slave audctl_i2c_slave_chk #(.DEV_ADDR(DEV_ADDR)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .ph      (ph_w),
    .rx_byte (rx_byte_w),
    .wr_en   (wr_en_w),
    .mode_q  (mode_q_w),
    .vol_q   (vol_q_w),
    .sda_pull(sda_pull_o),
    .left_en (left_en_o),
    .right_en(right_en_o),
    .mono_sum(mono_sum_o),
    .pump_en (pump_en_o),
    .bias_en (bias_en_o)
);

// File: tb/audctl_i2c_slave_tb_top.sv
module audctl_i2c_slave_tb_top;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_drv = 1'b1;
    logic       sda_drv = 1'b1;
    logic       sda_line;
    logic       sda_pull_o, left_en_o, right_en_o, mono_sum_o, pump_en_o, bias_en_o;
    logic       mute_left_o, mute_right_o;
    logic [5:0] vol_code_o;

    int   checks = 0;
    int   errs   = 0;
    bit   blackout = 1'b1;
    bit   done = 1'b0;
    logic [7:0] m_mode = 8'h00;
    logic [7:0] m_vol  = 8'hC0;

    always #4 clk = ~clk;

    assign sda_line = sda_drv & ~sda_pull_o;

    audctl_i2c_slave dut_i (
        .clk(clk), .rst(rst), .scl_i(scl_drv), .sda_i(sda_line),
        .sda_pull_o(sda_pull_o), .left_en_o(left_en_o), .right_en_o(right_en_o),
        .mono_sum_o(mono_sum_o), .pump_en_o(pump_en_o), .bias_en_o(bias_en_o),
        .mute_left_o(mute_left_o), .mute_right_o(mute_right_o), .vol_code_o(vol_code_o)
    );

    // expected {left, right, mono, pump, bias, muteL, muteR, vol[5:0]}
    function automatic logic [12:0] model_out();
        logic l, r, mo, p, b;
        l = 0; r = 0; mo = 0; p = 0; b = 0;
        if (m_vol[6] == 1'b0) begin
            p = 1;
            if (m_mode[4] == 1'b0) begin
                b  = ~m_mode[5];
                l  = ~m_mode[6];
                r  = ~m_mode[1];
                mo = m_mode[1] & ~m_mode[6];
            end
        end
        return {l, r, mo, p, b, m_mode[2], m_mode[0], m_vol[5:0]};
    endfunction

    function automatic logic [12:0] dut_out();
        return {left_en_o, right_en_o, mono_sum_o, pump_en_o, bias_en_o,
                mute_left_o, mute_right_o, vol_code_o};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !blackout && !done) begin
            checks++;
            if (dut_out() !== model_out()) begin
                errs++;
                $display("FAIL R5 R6 R7 R8 R9 R10 per-clock outputs: act=%0h exp=%0h",
                         dut_out(), model_out());
            end
        end
    end

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; wait_q();
        scl_drv = 1'b1; wait_q();
        sda_drv = 1'b0; wait_q();
        scl_drv = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; wait_q();
        scl_drv = 1'b1; wait_q();
        sda_drv = 1'b1; wait_q();
    endtask

    task automatic put_bit(logic b);
        sda_drv = b;    wait_q();
        scl_drv = 1'b1; wait_q(); wait_q();
        scl_drv = 1'b0; wait_q();
    endtask

    task automatic send_bits(logic [7:0] b, int n);
        for (int i = 7; i > 7 - n; i--) put_bit(b[i]);
    endtask

    task automatic send_byte(logic [7:0] b, logic exp_ack, string tag, bit commit);
        send_bits(b, 8);
        sda_drv = 1'b1; wait_q();
        scl_drv = 1'b1; wait_q();
        chk(tag, {31'd0, sda_pull_o}, {31'd0, exp_ack});
        wait_q();
        if (commit) begin
            blackout = 1'b1;
            if (b[7]) m_vol = b; else m_mode = b;
        end
        scl_drv = 1'b0;
        repeat (8) @(negedge clk);
        blackout = 1'b0;
        repeat (Q - 8) @(negedge clk);
    endtask

    task automatic write_reg(logic [7:0] d, string tag);
        bus_start();
        send_byte(8'hC0, 1'b1, tag, 1'b0);
        send_byte(d, 1'b1, tag, 1'b1);
        bus_stop();
        wait_q();
    endtask

    initial begin
        repeat (10) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        blackout = 1'b0;

        // R1 reset state
        chk("R1 outputs", {19'd0, dut_out()}, {19'd0, 13'h0000});
        chk("R1 sda_pull", {31'd0, sda_pull_o}, 32'd0);

        // R2 R5 volume write, shutdown cleared, code 42
        write_reg(8'hAA, "R2 ack");
        chk("R5 vol code", {26'd0, vol_code_o}, 32'd42);
        chk("R5 pump on", {31'd0, pump_en_o}, 32'd1);

        // R9 normal mode, bias on; bias off via bit 5; bit 3 has no effect
        write_reg(8'h00, "R2 ack");
        chk("R9 bias on", {29'd0, left_en_o, right_en_o, bias_en_o}, 32'h7);
        write_reg(8'h20, "R2 ack");
        chk("R9 bias off", {30'd0, bias_en_o, left_en_o}, 32'h1);
        write_reg(8'h08, "R2 ack");
        chk("R9 bit3 ignored", {19'd0, dut_out()}, {19'd0, 13'b1_1_0_1_1_0_0_101010});

        // R10 mutes
        write_reg(8'h05, "R2 ack");
        chk("R10 mutes", {30'd0, mute_left_o, mute_right_o}, 32'h3);

        // R8 channel shut-offs
        write_reg(8'h02, "R2 ack");
        chk("R8 right off mono", {29'd0, left_en_o, right_en_o, mono_sum_o}, 32'h5);
        write_reg(8'h42, "R2 ack");
        chk("R8 both off", {29'd0, left_en_o, right_en_o, pump_en_o}, 32'h1);
        write_reg(8'h40, "R2 ack");
        chk("R8 left off", {29'd0, left_en_o, right_en_o, mono_sum_o}, 32'h2);

        // R7 pump-only overrides channel bits
        write_reg(8'h52, "R2 ack");
        chk("R7 pump only", {28'd0, pump_en_o, left_en_o, right_en_o, bias_en_o}, 32'h8);
        write_reg(8'h14, "R2 ack");
        chk("R7 pump only mute kept", {29'd0, pump_en_o, bias_en_o, mute_left_o}, 32'h5);

        // R6 global shutdown
        write_reg(8'h00, "R2 ack");
        write_reg(8'hC0, "R2 ack");
        chk("R6 all off", {27'd0, left_en_o, right_en_o, mono_sum_o, pump_en_o, bias_en_o}, 32'h0);
        write_reg(8'hBF, "R2 ack");
        chk("R5 full code", {25'd0, pump_en_o, vol_code_o}, {25'd0, 1'b1, 6'd63});

        // R3 wrong address
        bus_start();
        send_byte(8'hC2, 1'b0, "R3 addr nack", 1'b0);
        send_byte(8'h81, 1'b0, "R3 data nack", 1'b0);
        bus_stop(); wait_q();
        bus_start();
        send_byte(8'h40, 1'b0, "R3 addr nack high bit", 1'b0);
        bus_stop(); wait_q();
        chk("R3 vol kept", {26'd0, vol_code_o}, 32'd63);

        // R4 read request ignored until next START
        bus_start();
        send_byte(8'hC1, 1'b0, "R4 read nack", 1'b0);
        send_byte(8'hC0, 1'b0, "R4 no start nack", 1'b0);
        send_byte(8'h80, 1'b0, "R4 ignored data", 1'b0);
        bus_stop(); wait_q();
        chk("R4 vol kept", {26'd0, vol_code_o}, 32'd63);
        write_reg(8'h85, "R4 later write ack");
        chk("R4 later write", {26'd0, vol_code_o}, 32'd5);

        // R11 START inside a data byte
        bus_start();
        send_byte(8'hC0, 1'b1, "R11 addr ack", 1'b0);
        send_bits(8'h8A, 5);
        bus_start();
        send_byte(8'hC0, 1'b1, "R11 restart addr ack", 1'b0);
        send_byte(8'h83, 1'b1, "R11 restart data ack", 1'b1);
        bus_stop(); wait_q();
        chk("R11 partial discarded", {26'd0, vol_code_o}, 32'd3);
        // R11 STOP inside a data byte
        bus_start();
        send_byte(8'hC0, 1'b1, "R11 addr ack", 1'b0);
        send_bits(8'hFF, 4);
        bus_stop(); wait_q();
        chk("R11 stop discards", {25'd0, pump_en_o, vol_code_o}, {25'd0, 1'b1, 6'd3});

        // R12 second data byte
        bus_start();
        send_byte(8'hC0, 1'b1, "R12 addr ack", 1'b0);
        send_byte(8'h01, 1'b1, "R12 first ack", 1'b1);
        send_byte(8'h84, 1'b0, "R12 second nack", 1'b0);
        bus_stop(); wait_q();
        chk("R12 second dropped", {25'd0, mute_right_o, vol_code_o}, {25'd0, 1'b1, 6'd3});

        // R8 R5 repeated START right after a committed acknowledge
        bus_start();
        send_byte(8'hC0, 1'b1, "R2 ack", 1'b0);
        send_byte(8'h02, 1'b1, "R2 ack", 1'b1);
        bus_start();
        send_byte(8'hC0, 1'b1, "R2 ack", 1'b0);
        send_byte(8'h9F, 1'b1, "R2 ack", 1'b1);
        bus_stop(); wait_q();
        chk("R8 mono after restart", {31'd0, mono_sum_o}, 32'd1);
        chk("R5 vol after restart", {26'd0, vol_code_o}, 32'd31);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errs++;
            $display("FAIL watchdog: act=running exp=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule